// File: doc/BRIEF.md
# Per-Channel Trigger Prioritizer

The block gathers trigger requests for a set of DMA channels and turns them into event-queue writes, one entry per cycle. Each channel accepts three kinds of request: a hardware event, a chain request raised by another finished transfer, and a software request. Every kind sets its own pending flag for that channel. Requests that arrive together on one channel are never folded into one. Each becomes its own queue entry, and the three kinds are taken in a fixed rank.

Each cycle the block picks one (channel, source) pair. It takes the lowest-numbered channel that has at least one flag set and whose target queue can accept an entry. Inside that channel it takes the highest-ranked flag. A per-channel programmable queue number routes the entry to one of the event queues. The chosen flag alone is cleared, and a registered write carries the channel number, source code and queue number to the queues. The queues themselves sit outside the block. Each queue reports through one ready bit whether it will take a write presented in the following cycle.

Top module: `chan_trig_prio`

## Requirements
- R1: After reset no flag is pending and `q_wr_o` stays low until a request pulse arrives.
- R2: A one-cycle request pulse sampled at clock edge k produces `q_wr_o` high in the cycle after edge k+1, provided the target queue is ready.
- R3: Source codes on `q_src_o` are 0 for hardware event, 1 for chain and 2 for software. Flags pending together on one channel are written out in the order 0, then 1, then 2, in consecutive cycles.
- R4: Every pending flag yields exactly one entry, and a write clears only the flag it serviced. Three simultaneous flags give three entries.
- R5: Across channels the lowest-numbered eligible channel is serviced first, whatever source the higher channels carry.
- R6: `q_sel_o` equals the channel's field of `chan_qsel_i`. The field of channel c sits at bits [c*QW +: QW].
- R7: While a channel's target queue ready bit is low, no entry is written for it and its flags stay pending. They are written once the bit rises.
- R8: A channel held back by a busy queue does not block a higher-numbered channel whose queue is ready.
- R9: A request pulse in the same cycle as the clear of that same flag leaves the flag set, so a second entry follows.
- R10: A repeated request on a flag that is already pending adds no entry.
- R11: At most one write per cycle, and only when the selected queue's ready bit was high at the selecting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | NCH | Hardware event request pulses, one per channel |
| chn_set_i | input | NCH | Chain request pulses, one per channel |
| man_set_i | input | NCH | Software request pulses, one per channel |
| chan_qsel_i | input | NCH*QW | Target queue number per channel |
| q_rdy_i | input | NQ | Per-queue ready: the queue takes a write in the next cycle |
| q_wr_o | output | 1 | Queue write strobe (registered) |
| q_chan_o | output | CW | Channel number of the entry |
| q_src_o | output | 2 | Source code of the entry |
| q_sel_o | output | QW | Queue that receives the entry |

## Verification
Two registers sit between a request pulse and the write. The pulse is latched into its flag at the first edge, and the selection is registered at the second. So the first entry is due on the negative edge after the second rising edge, and later entries of a burst follow on each consecutive negative edge. The bench drives and samples only on negative edges. It checks the exact cycle for the single-pulse case, reads the logged order of entries for the multi-flag cases, and waits a fixed number of cycles before checking that a held or repeated flag produced no entry.

// File: rtl/chan_trig_pkg.sv
package chan_trig_pkg;
  localparam int NUM_SRC = 3;

  // rank order: lower code wins inside a channel
  typedef enum logic [1:0] {
    SRC_EVT = 2'd0,
    SRC_CHN = 2'd1,
    SRC_MAN = 2'd2
  } trig_src_e;
endpackage

// File: rtl/chan_trig_pend.sv
module chan_trig_pend #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] pend_o
);
  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | set_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(set_i[c])) |-> pend_o[c]);
  end
endmodule

// File: rtl/chan_trig_pick.sv
module chan_trig_pick
  import chan_trig_pkg::*;
#(
  parameter int NCH = 8,
  parameter int NQ  = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SRC-1:0][NCH-1:0] pend_i,
  input  logic [NCH*QW-1:0]           chan_qsel_i,
  input  logic [NQ-1:0]               q_rdy_i,
  output logic                        win_o,
  output logic [CW-1:0]               win_chan_o,
  output trig_src_e                   win_src_o,
  output logic [QW-1:0]               win_q_o,
  output logic [NUM_SRC-1:0][NCH-1:0] clr_o
);
  logic [QW-1:0] qsel_a [NCH];
  logic [NCH-1:0] elig;

  for (genvar c = 0; c < NCH; c++) begin : g_elig
    logic any_pend;
    assign qsel_a[c] = chan_qsel_i[c*QW +: QW];
    assign any_pend  = pend_i[SRC_EVT][c] | pend_i[SRC_CHN][c] | pend_i[SRC_MAN][c];
    if (NQ == (1 << QW)) begin : g_full
      assign elig[c] = any_pend & q_rdy_i[qsel_a[c]];
    end else begin : g_part
      assign elig[c] = any_pend & (qsel_a[c] < QW'(NQ)) & q_rdy_i[qsel_a[c]];
    end
  end

  always_comb begin
    win_o      = 1'b0;
    win_chan_o = '0;
    for (int c = NCH-1; c >= 0; c--) begin
      if (elig[c]) begin
        win_o      = 1'b1;
        win_chan_o = CW'(c);
      end
    end
    if (pend_i[SRC_EVT][win_chan_o])      win_src_o = SRC_EVT;
    else if (pend_i[SRC_CHN][win_chan_o]) win_src_o = SRC_CHN;
    else                                  win_src_o = SRC_MAN;
    win_q_o = qsel_a[win_chan_o];
    clr_o   = '0;
    if (win_o) clr_o[win_src_o][win_chan_o] = 1'b1;
  end

  assert_clr_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o & ~pend_i) == '0);
  assert_one_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
endmodule

// File: rtl/chan_trig_prio.sv
module chan_trig_prio
  import chan_trig_pkg::*;
#(
  parameter int NCH = 8,
  parameter int NQ  = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    evt_set_i,
  input  logic [NCH-1:0]    chn_set_i,
  input  logic [NCH-1:0]    man_set_i,
  input  logic [NCH*QW-1:0] chan_qsel_i,
  input  logic [NQ-1:0]     q_rdy_i,
  output logic              q_wr_o,
  output logic [CW-1:0]     q_chan_o,
  output logic [1:0]        q_src_o,
  output logic [QW-1:0]     q_sel_o
);
  logic [NUM_SRC-1:0][NCH-1:0] set_v, clr_v, pend_v;
  logic          win;
  logic [CW-1:0] win_chan;
  trig_src_e     win_src;
  logic [QW-1:0] win_q;

  assign set_v[SRC_EVT] = evt_set_i;
  assign set_v[SRC_CHN] = chn_set_i;
  assign set_v[SRC_MAN] = man_set_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_bank
    chan_trig_pend #(.NCH(NCH)) u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[s]),
      .clr_i  (clr_v[s]),
      .pend_o (pend_v[s])
    );
  end

  chan_trig_pick #(.NCH(NCH), .NQ(NQ)) u_pick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend_v),
    .chan_qsel_i (chan_qsel_i),
    .q_rdy_i     (q_rdy_i),
    .win_o       (win),
    .win_chan_o  (win_chan),
    .win_src_o   (win_src),
    .win_q_o     (win_q),
    .clr_o       (clr_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_wr_o   <= 1'b0;
      q_chan_o <= '0;
      q_src_o  <= '0;
      q_sel_o  <= '0;
    end else begin
      q_wr_o <= win;
      if (win) begin
        q_chan_o <= win_chan;
        q_src_o  <= win_src;
        q_sel_o  <= win_q;
      end
    end
  end

  assert_rdy_on_push_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_wr_o |-> |($past(q_rdy_i) & (NQ'(1) << q_sel_o)));
  assert_evt_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_wr_o && q_src_o != SRC_EVT) |->
      (($past(pend_v[SRC_EVT]) >> q_chan_o) & NCH'(1)) == '0);
  assert_chn_before_man_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_wr_o && q_src_o == SRC_MAN) |->
      (($past(pend_v[SRC_CHN]) >> q_chan_o) & NCH'(1)) == '0);
  assert_qsel_map_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_wr_o |-> q_sel_o == QW'($past(chan_qsel_i) >> (q_chan_o * QW)));
  assert_src_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_wr_o |-> q_src_o != 2'd3);
endmodule

// File: tb/chan_trig_prio_tb.sv
module chan_trig_prio_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int NQ  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] evt_set = '0, chn_set = '0, man_set = '0;
  logic [NCH-1:0] qsel = 8'b0010_0100; // ch2, ch5 -> queue 1
  logic [NQ-1:0]  q_rdy = 2'b11;
  logic           q_wr;
  logic [2:0]     q_chan;
  logic [1:0]     q_src;
  logic           q_sel;

  int checks = 0, fails = 0;
  int log_n = 0;
  int log_chan [32];
  int log_src  [32];
  int log_sel  [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_trig_prio #(.NCH(NCH), .NQ(NQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_set_i(evt_set), .chn_set_i(chn_set), .man_set_i(man_set),
    .chan_qsel_i(qsel), .q_rdy_i(q_rdy),
    .q_wr_o(q_wr), .q_chan_o(q_chan), .q_src_o(q_src), .q_sel_o(q_sel)
  );

  always @(negedge clk) begin
    if (rst_n && q_wr && log_n < 32) begin
      log_chan[log_n] = int'(q_chan);
      log_src[log_n]  = int'(q_src);
      log_sel[log_n]  = int'(q_sel);
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_entry(input int idx, input int ch, input int src, input int sel,
                           input string req);
    chk(log_n > idx, req, log_n, idx + 1);
    if (log_n > idx) begin
      chk(log_chan[idx] == ch, req, log_chan[idx], ch);
      chk(log_src[idx] == src, req, log_src[idx], src);
      chk(log_sel[idx] == sel, req, log_sel[idx], sel);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle pulse; returns at the negedge after the latching edge
  task automatic pulse(input logic [NCH-1:0] e, input logic [NCH-1:0] c,
                       input logic [NCH-1:0] m);
    @(negedge clk);
    evt_set = e; chn_set = c; man_set = m;
    @(negedge clk);
    evt_set = '0; chn_set = '0; man_set = '0;
  endtask

  task automatic t_reset;
    chk(q_wr == 1'b0, "R1 write low after reset", int'(q_wr), 0);
    log_n = 0;
    settle(4);
    chk(log_n == 0, "R1 no entries without requests", log_n, 0);
  endtask

  task automatic t_latency;
    log_n = 0;
    pulse('0, '0, 8'b0000_0100);
    chk(q_wr == 1'b0, "R2 no write one cycle after latch", int'(q_wr), 0);
    @(negedge clk);
    chk(q_wr == 1'b1, "R2 write due after second edge", int'(q_wr), 1);
    settle(3);
    chk(log_n == 1, "R2 single entry", log_n, 1);
    chk_entry(0, 2, 2, 1, "R6 ch2 software to queue 1");
  endtask

  task automatic t_order;
    log_n = 0;
    pulse(8'b0001_0000, 8'b0001_0000, 8'b0001_0000);
    settle(5);
    chk(log_n == 3, "R4 three entries from one channel", log_n, 3);
    chk_entry(0, 4, 0, 0, "R3 event first");
    chk_entry(1, 4, 1, 0, "R3 chain second");
    chk_entry(2, 4, 2, 0, "R3 software third");
  endtask

  task automatic t_cross;
    log_n = 0;
    pulse(8'b0100_0000, 8'b0000_0001, 8'b0000_0010);
    settle(5);
    chk(log_n == 3, "R5 entry count", log_n, 3);
    chk_entry(0, 0, 1, 0, "R5 ch0 first");
    chk_entry(1, 1, 2, 0, "R5 ch1 second");
    chk_entry(2, 6, 0, 0, "R5 ch6 last");
  endtask

  task automatic t_block;
    log_n = 0;
    q_rdy = 2'b00;
    pulse(8'b0000_1000, '0, '0);
    settle(5);
    chk(log_n == 0, "R7 held while queue busy", log_n, 0);
    q_rdy = 2'b01;
    settle(3);
    chk(log_n == 1, "R7 released when ready", log_n, 1);
    chk_entry(0, 3, 0, 0, "R7 held entry");
    q_rdy = 2'b11;
  endtask

  task automatic t_bypass;
    log_n = 0;
    q_rdy = 2'b10;
    pulse(8'b0000_0010, 8'b0010_0000, '0);
    settle(4);
    chk(log_n == 1, "R8 only ready queue served", log_n, 1);
    chk_entry(0, 5, 1, 1, "R8 ch5 passes blocked ch1");
    q_rdy = 2'b11;
    settle(3);
    chk(log_n == 2, "R8 blocked channel follows", log_n, 2);
    chk_entry(1, 1, 0, 0, "R8 ch1 after release");
  endtask

  task automatic t_set_on_clear;
    log_n = 0;
    @(negedge clk);
    evt_set = 8'b0000_1000;
    @(negedge clk);
    @(negedge clk);
    evt_set = '0;
    settle(4);
    chk(log_n == 2, "R9 set during clear gives second entry", log_n, 2);
    chk_entry(0, 3, 0, 0, "R9 first entry");
    chk_entry(1, 3, 0, 0, "R9 second entry");
  endtask

  task automatic t_collapse;
    log_n = 0;
    q_rdy = 2'b00;
    pulse('0, 8'b0100_0000, '0);
    settle(1);
    pulse('0, 8'b0100_0000, '0);
    settle(2);
    q_rdy = 2'b11;
    settle(4);
    chk(log_n == 1, "R10 repeat on pending flag adds nothing", log_n, 1);
    chk_entry(0, 6, 1, 0, "R10 single chain entry");
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_order();
    t_cross();
    t_block();
    t_bypass();
    t_set_on_clear();
    t_collapse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule